// File: doc/BRIEF.md
# Cassette Tape Pulse-Duration Deserializer

This block turns the squared-up signal from a cassette playback comparator back into bytes. It watches rising edges on the tape input and measures the time between them. A bit is made of one signal cycle or two signal cycles, followed by a silent gap. One cycle means 0 and two cycles mean 1. Reception is gated. The receiver first has to hear a long run of 0 bits (the leader). A single 1 bit then marks where the frame begins.

A frame carries a fixed number of name bytes, then a length byte, then that many data bytes, then a checksum byte. The checksum is the XOR of the data bytes. Name, length and data bytes leave the block as single-cycle strobes, with a tag that tells header bytes from data bytes. A matching checksum raises `done`. A mismatch, or a badly timed cycle once the receiver is locked, raises `err` and aborts the frame. Both flags hold until the next leader lock. All timing is in clock cycles, set by one nominal-cycle parameter.

Top module: `cas_tape_rx`

## Requirements
- R1: After reset, `out_vld`, `done` and `err` are 0.
- R2: A rising-edge interval of NOM_CLKS-NOM_CLKS/4 to NOM_CLKS+NOM_CLKS/4 clocks, inclusive, is a valid cycle. A bit ends when NOM_CLKS+NOM_CLKS/2 clocks pass with no new rising edge. A bit with one cycle decodes as 0 and a bit with two cycles decodes as 1, across that whole tolerance band.
- R3: Lock needs LEAD_BITS consecutive 0 bits. Before lock, a 1 bit or a mistimed interval restarts that count, sets no flag and produces no byte strobe.
- R4: After lock, further 0 bits are ignored. The first 1 bit is a sync bit that starts the frame, and it is not part of any byte. Bytes are assembled from 8 bits, most significant bit first.
- R5: The frame is NAME_LEN name bytes, one length byte L, L data bytes and one checksum byte. Name and length bytes strobe with `out_hdr`=1, data bytes strobe with `out_hdr`=0, and the checksum byte is not output. Every strobe lasts one clock.
- R6: With L=0, the byte after the length byte is taken as the checksum, and it must equal 0x00.
- R7: When the checksum equals the XOR of the L data bytes, `done` goes to 1 and the receiver returns to leader search.
- R8: When the checksum does not match, `err` goes to 1, `done` stays 0, and the receiver returns to leader search.
- R9: After lock, a mistimed interval (including a third cycle within one bit) sets `err` and aborts the frame. No further strobes appear until a new lock.
- R10: `done` and `err` hold their values until the next leader lock, and that lock clears both.
- R11: `done` and `err` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ear_in | input | 1 | Comparator output from tape playback, asynchronous |
| out_vld | output | 1 | One-clock strobe for a received byte |
| out_byte | output | DW | Received byte |
| out_hdr | output | 1 | 1 for a name or length byte, 0 for a data byte |
| done | output | 1 | Frame received with a good checksum |
| err | output | 1 | Frame aborted: bad checksum or mistimed cycle |

## Verification
A rising edge on `ear_in` reaches the interval counter three clocks later. A bit is decided exactly NOM_CLKS+NOM_CLKS/2 clocks after its last rising edge. The byte strobe follows two clocks after the bit decision, and `done` or `err` for the checksum byte appears at that same point. The bench monitor samples `out_vld` at every falling edge and pops the next expected byte from a queue, so both order and content are checked without needing a fixed arrival cycle. Flags and queue emptiness are checked only after a quiet period longer than the full timeout-plus-pipeline path, and always before the next leader starts.

// File: rtl/cas_rx_pkg.sv
package cas_rx_pkg;

   typedef enum logic [2:0] {
      ST_HUNT,
      ST_ARMED,
      ST_HDR,
      ST_DATA,
      ST_SUM
   } frm_state_e;

   typedef enum logic {
      TM_IDLE,
      TM_INBIT
   } tmr_state_e;

   // shortest rise-to-rise interval accepted as one cycle
   function automatic int win_lo(input int nom);
      return nom - nom / 4;
   endfunction

   // longest rise-to-rise interval accepted as one cycle
   function automatic int win_hi(input int nom);
      return nom + nom / 4;
   endfunction

   // silence after the last rising edge that closes a bit
   function automatic int bit_end(input int nom);
      return nom + nom / 2;
   endfunction

endpackage

// File: rtl/cas_sync_edge.sv
module cas_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cas_sync_edge: STAGES must be at least 2");
   end

   // [STAGES-1:0] synchronizer, [STAGES] delayed copy for edge detect
   logic [STAGES:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], din};
   end

   assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/cas_bit_timer.sv
module cas_bit_timer
   import cas_rx_pkg::*;
#(
   parameter int NOM_CLKS = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rise,
   output logic bit_vld,
   output logic bit_val,
   output logic cyc_err
);
   localparam int LO    = win_lo(NOM_CLKS);
   localparam int HI    = win_hi(NOM_CLKS);
   localparam int END_T = bit_end(NOM_CLKS);
   localparam int CW    = $clog2(END_T + 2);
   localparam logic [CW-1:0] LO_C  = CW'(LO);
   localparam logic [CW-1:0] HI_C  = CW'(HI);
   localparam logic [CW-1:0] END_C = CW'(END_T);

   if (NOM_CLKS < 8) begin : g_bad_nom
      $error("cas_bit_timer: NOM_CLKS must be at least 8");
   end

   tmr_state_e     st;
   logic [CW-1:0]  cnt;     // clocks since the last rising edge
   logic           two;     // second cycle seen in this bit
   logic           in_win;

   assign in_win = (cnt >= LO_C) && (cnt <= HI_C);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= TM_IDLE;
         cnt     <= '0;
         two     <= 1'b0;
         bit_vld <= 1'b0;
         bit_val <= 1'b0;
         cyc_err <= 1'b0;
      end else begin
         bit_vld <= 1'b0;
         cyc_err <= 1'b0;
         if (rise) begin
            cnt <= CW'(1);
            if (st == TM_IDLE) begin
               st  <= TM_INBIT;
               two <= 1'b0;
            end else if (in_win && !two) begin
               two <= 1'b1;
            end else begin
               // mistimed or third cycle: flag it, restart from this edge
               cyc_err <= 1'b1;
               two     <= 1'b0;
            end
         end else if (st == TM_INBIT) begin
            if (cnt == END_C) begin
               bit_vld <= 1'b1;
               bit_val <= two;
               st      <= TM_IDLE;
            end else begin
               cnt <= cnt + CW'(1);
            end
         end
      end
   end
endmodule

// File: rtl/cas_byte_pack.sv
module cas_byte_pack #(
   parameter int W         = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         bit_vld,
   input  logic         bit_val,
   output logic         byte_vld,
   output logic [W-1:0] byte_out
);
   localparam int CNW = $clog2(W);
   localparam logic [CNW-1:0] LAST = CNW'(W - 1);

   if (W < 2) begin : g_bad_w
      $error("cas_byte_pack: W must be at least 2");
   end

   logic [W-1:0]   sh;
   logic [W-1:0]   nxt;
   logic [CNW-1:0] nb;

   if (MSB_FIRST) begin : g_msb
      assign nxt = {sh[W-2:0], bit_val};
   end else begin : g_lsb
      assign nxt = {bit_val, sh[W-1:1]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh       <= '0;
         nb       <= '0;
         byte_vld <= 1'b0;
         byte_out <= '0;
      end else begin
         byte_vld <= 1'b0;
         if (clr) begin
            sh <= '0;
            nb <= '0;
         end else if (bit_vld) begin
            sh <= nxt;
            if (nb == LAST) begin
               nb       <= '0;
               byte_vld <= 1'b1;
               byte_out <= nxt;
            end else begin
               nb <= nb + CNW'(1);
            end
         end
      end
   end
endmodule

// File: rtl/cas_frame.sv
module cas_frame
   import cas_rx_pkg::*;
#(
   parameter int DW        = 8,
   parameter int NAME_LEN  = 2,
   parameter int LEAD_BITS = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bit_vld,
   input  logic          bit_val,
   input  logic          cyc_err,
   input  logic          byte_vld,
   input  logic [DW-1:0] byte_in,
   output logic          pk_clr,
   output logic          lock_now,
   output logic          out_vld,
   output logic [DW-1:0] out_byte,
   output logic          out_hdr,
   output logic          done,
   output logic          err
);
   localparam int LCW = $clog2(LEAD_BITS + 1);
   localparam int IW  = $clog2(NAME_LEN + 2);
   localparam logic [LCW-1:0] LEAD_LAST = LCW'(LEAD_BITS - 1);
   localparam logic [IW-1:0]  LEN_IDX   = IW'(NAME_LEN);

   if (LEAD_BITS < 2) begin : g_bad_lead
      $error("cas_frame: LEAD_BITS must be at least 2");
   end
   if (NAME_LEN < 0) begin : g_bad_name
      $error("cas_frame: NAME_LEN must not be negative");
   end

   frm_state_e     st;
   logic [LCW-1:0] lead;
   logic [IW-1:0]  idx;
   logic [DW-1:0]  remain;
   logic [DW-1:0]  csum;

   assign lock_now = (st == ST_HUNT) && bit_vld && !bit_val && (lead == LEAD_LAST);
   assign pk_clr   = (st == ST_ARMED) && bit_vld && bit_val;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_HUNT;
         lead     <= '0;
         idx      <= '0;
         remain   <= '0;
         csum     <= '0;
         out_vld  <= 1'b0;
         out_byte <= '0;
         out_hdr  <= 1'b0;
         done     <= 1'b0;
         err      <= 1'b0;
      end else begin
         out_vld <= 1'b0;
         if (st != ST_HUNT && cyc_err) begin
            err  <= 1'b1;
            done <= 1'b0;
            st   <= ST_HUNT;
            lead <= '0;
         end else begin
            unique case (st)
               ST_HUNT: begin
                  if (cyc_err || (bit_vld && bit_val)) begin
                     lead <= '0;
                  end else if (bit_vld) begin
                     if (lead == LEAD_LAST) begin
                        st   <= ST_ARMED;
                        lead <= '0;
                        done <= 1'b0;
                        err  <= 1'b0;
                     end else begin
                        lead <= lead + LCW'(1);
                     end
                  end
               end
               ST_ARMED: begin
                  if (bit_vld && bit_val) begin
                     st   <= ST_HDR;
                     idx  <= '0;
                     csum <= '0;
                  end
               end
               ST_HDR: begin
                  if (byte_vld) begin
                     out_vld  <= 1'b1;
                     out_byte <= byte_in;
                     out_hdr  <= 1'b1;
                     if (idx == LEN_IDX) begin
                        remain <= byte_in;
                        st     <= (byte_in == '0) ? ST_SUM : ST_DATA;
                     end else begin
                        idx <= idx + IW'(1);
                     end
                  end
               end
               ST_DATA: begin
                  if (byte_vld) begin
                     out_vld  <= 1'b1;
                     out_byte <= byte_in;
                     out_hdr  <= 1'b0;
                     csum     <= csum ^ byte_in;
                     remain   <= remain - DW'(1);
                     if (remain == DW'(1)) st <= ST_SUM;
                  end
               end
               ST_SUM: begin
                  if (byte_vld) begin
                     if (byte_in == csum) done <= 1'b1;
                     else                 err  <= 1'b1;
                     st <= ST_HUNT;
                  end
               end
               default: st <= ST_HUNT;
            endcase
         end
      end
   end
endmodule

// File: rtl/cas_tape_rx.sv
module cas_tape_rx #(
   parameter int DW          = 8,
   parameter int NOM_CLKS    = 40,
   parameter int LEAD_BITS   = 64,
   parameter int NAME_LEN    = 2,
   parameter int SYNC_STAGES = 2,
   parameter bit MSB_FIRST   = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ear_in,
   output logic          out_vld,
   output logic [DW-1:0] out_byte,
   output logic          out_hdr,
   output logic          done,
   output logic          err
);
   logic          rise;
   logic          bit_vld;
   logic          bit_val;
   logic          cyc_err;
   logic          pk_clr;
   logic          lock_now;
   logic          byte_vld;
   logic [DW-1:0] byte_w;

   cas_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (ear_in),
      .rise (rise)
   );

   cas_bit_timer #(.NOM_CLKS(NOM_CLKS)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .rise   (rise),
      .bit_vld(bit_vld),
      .bit_val(bit_val),
      .cyc_err(cyc_err)
   );

   cas_byte_pack #(.W(DW), .MSB_FIRST(MSB_FIRST)) u_pack (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (pk_clr),
      .bit_vld (bit_vld),
      .bit_val (bit_val),
      .byte_vld(byte_vld),
      .byte_out(byte_w)
   );

   cas_frame #(.DW(DW), .NAME_LEN(NAME_LEN), .LEAD_BITS(LEAD_BITS)) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_vld (bit_vld),
      .bit_val (bit_val),
      .cyc_err (cyc_err),
      .byte_vld(byte_vld),
      .byte_in (byte_w),
      .pk_clr  (pk_clr),
      .lock_now(lock_now),
      .out_vld (out_vld),
      .out_byte(out_byte),
      .out_hdr (out_hdr),
      .done    (done),
      .err     (err)
   );
endmodule

// File: rtl/cas_tape_rx_chk.sv
module cas_tape_rx_chk (
   input logic clk,
   input logic rst_n,
   input logic out_vld,
   input logic done,
   input logic err,
   input logic lock_now
);
   a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));

   a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |=> !out_vld);

   a_r10_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !lock_now) |=> err);

   a_r10_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !lock_now) |=> done);

   a_r10_clear_on_lock: assert property (@(posedge clk) disable iff (!rst_n)
      lock_now |=> (!done && !err));

   a_r9_quiet_after_err: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !out_vld);

   a_r7_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !out_vld);
endmodule

bind cas_tape_rx cas_tape_rx_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .out_vld (out_vld),
   .done    (done),
   .err     (err),
   .lock_now(lock_now)
);

// File: tb/cas_tape_rx_bench.sv
`timescale 1ns/1ps
module cas_tape_rx_bench;
   localparam int NOM  = 40;
   localparam int GAP  = 32;
   localparam int WAIT = 2 * NOM;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       ear;
   logic       out_vld;
   logic [7:0] out_byte;
   logic       out_hdr;
   logic       done;
   logic       err;

   int n_chk = 0;
   int n_bad = 0;
   string cur_tag = "R1";

   logic [8:0] exp_q[$];
   string      tag_q[$];
   logic [7:0] payload[$];
   logic [8:0] e_item;
   string      e_tag;

   always #2.5 clk = ~clk;

   cas_tape_rx u_cas_tape_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .ear_in  (ear),
      .out_vld (out_vld),
      .out_byte(out_byte),
      .out_hdr (out_hdr),
      .done    (done),
      .err     (err)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n === 1'b1 && out_vld === 1'b1) begin
         if (exp_q.size() == 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL %s unexpected byte act=%0h exp=none", cur_tag, {out_hdr, out_byte});
         end else begin
            e_item = exp_q.pop_front();
            e_tag  = tag_q.pop_front();
            chk(e_tag, {23'd0, out_hdr, out_byte}, {23'd0, e_item});
         end
      end
   end

   task automatic push_exp(input logic hdr, input logic [7:0] b, input string tag);
      exp_q.push_back({hdr, b});
      tag_q.push_back(tag);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      ear   = 1'b0;
      exp_q.delete();
      tag_q.delete();
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
   endtask

   task automatic send_cycle(input int per);
      ear = 1'b1;
      repeat (per / 2) @(negedge clk);
      ear = 1'b0;
      repeat (per - per / 2) @(negedge clk);
   endtask

   task automatic send_bit(input logic b, input int per);
      send_cycle(per);
      if (b) send_cycle(per);
      repeat (GAP) @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] v, input int per);
      for (int i = 7; i >= 0; i--) send_bit(v[i], per);
   endtask

   task automatic send_leader(input int n);
      for (int i = 0; i < n; i++) send_bit(1'b0, NOM);
   endtask

   // two cycles of 20 clocks: second interval is far below the window
   task automatic send_bad();
      send_cycle(20);
      send_cycle(20);
      repeat (GAP) @(negedge clk);
   endtask

   // sync bit, two name bytes, length, payload, checksum (xor ^ mask)
   task automatic send_frame(input logic [7:0] n0, input logic [7:0] n1,
                             input logic [7:0] mask, input int per,
                             input bit expect_out, input string tag);
      logic [7:0] sum;
      sum = 8'h00;
      foreach (payload[k]) sum = sum ^ payload[k];
      if (expect_out) begin
         push_exp(1'b1, n0, tag);
         push_exp(1'b1, n1, tag);
         push_exp(1'b1, 8'(payload.size()), tag);
         foreach (payload[k]) push_exp(1'b0, payload[k], tag);
      end
      send_bit(1'b1, NOM);
      send_byte(n0, per);
      send_byte(n1, per);
      send_byte(8'(payload.size()), per);
      foreach (payload[k]) send_byte(payload[k], per);
      send_byte(sum ^ mask, per);
      repeat (WAIT) @(negedge clk);
   endtask

   task automatic check_end(input string tag, input logic exp_done, input logic exp_err);
      chk({tag, " queue drained"}, 32'(exp_q.size()), 32'd0);
      chk({tag, " done"}, {31'd0, done}, {31'd0, exp_done});
      chk({tag, " err"},  {31'd0, err},  {31'd0, exp_err});
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      ear   = 1'b0;
      do_reset();

      // R1: reset state
      cur_tag = "R1";
      chk("R1 out_vld", {31'd0, out_vld}, 32'd0);
      chk("R1 done",    {31'd0, done},    32'd0);
      chk("R1 err",     {31'd0, err},     32'd0);

      // R2 R4 R5 R7: good frame, long leader, MSB-first values 80/01 distinct
      cur_tag = "R7";
      send_leader(70);
      payload = '{8'h80, 8'h01, 8'hE7};
      send_frame(8'h5A, 8'hC3, 8'h00, NOM, 1'b1, "R4_R5");
      check_end("R7", 1'b1, 1'b0);

      // R8 + R10: exact-length leader clears done, corrupted checksum
      cur_tag = "R8";
      send_leader(64);
      payload = '{8'hAA, 8'h55};
      send_frame(8'h11, 8'h22, 8'hFF, NOM, 1'b1, "R8");
      check_end("R8", 1'b0, 1'b1);

      // R6 + R10 + R2 tolerance: short cycles (per 32), zero length
      cur_tag = "R6";
      send_leader(64);
      chk("R10 err cleared by lock", {31'd0, err}, 32'd0);
      payload.delete();
      send_frame(8'h00, 8'hFF, 8'h00, 32, 1'b1, "R6");
      check_end("R6", 1'b1, 1'b0);

      // R2 tolerance upper side: per 48
      cur_tag = "R2";
      send_leader(64);
      payload = '{8'hF0, 8'h3B};
      send_frame(8'h9C, 8'h6D, 8'h00, 48, 1'b1, "R2");
      check_end("R2", 1'b1, 1'b0);

      // R9: mistimed cycle inside length byte aborts the frame
      cur_tag = "R9";
      send_leader(64);
      send_bit(1'b1, NOM);
      push_exp(1'b1, 8'h12, "R9");
      push_exp(1'b1, 8'h34, "R9");
      send_byte(8'h12, NOM);
      send_byte(8'h34, NOM);
      send_bit(1'b0, NOM);
      send_bad();
      for (int i = 0; i < 8; i++) send_bit(1'b1, NOM);
      repeat (WAIT) @(negedge clk);
      check_end("R9", 1'b0, 1'b1);

      // R3: leader one bit short never locks
      do_reset();
      cur_tag = "R3";
      send_leader(63);
      payload = '{8'h3C};
      send_frame(8'hFF, 8'hFF, 8'h00, NOM, 1'b0, "R3");
      check_end("R3 short leader", 1'b0, 1'b0);

      // R3: mistimed interval before lock restarts the count, no flag
      do_reset();
      send_leader(40);
      send_bad();
      send_leader(30);
      send_frame(8'hFF, 8'hFF, 8'h00, NOM, 1'b0, "R3");
      check_end("R3 glitch", 1'b0, 1'b0);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule